// File: doc/BRIEF.md
# Local-to-PCI Bus Window Translator

This block sits between a local bus master and a PCI-style cycle generator. It claims every local request whose address lies in a fixed 1 GB window (top two address bits equal to `2'b10`). It turns each claimed request into one bus command with an address, write data and byte enables. When the cycle completes, it returns one response carrying read data and a status code.

A small control file selects how the window is used. In memory mode, the bus address keeps the low 30 request bits, and a two-bit register field supplies the top two bits. In configuration mode, the low request bits are read as device, function and register fields. The block then builds a configuration address with a single IDSEL bit set at position 13 plus the device number. Requests that would land outside the 1 MB configuration window are refused without any bus cycle. An abort reported by the bus sets a sticky flag that software clears by writing one to it.

All three data paths use valid/ready handshakes. A transfer takes place on a rising edge where valid and ready are both high. A master that raises valid must hold it, and the payload, until that edge. The block holds `bus_*` and `rsp_*` stable while their ready inputs are low. Only one request is in flight at a time, so `req_ready` stays low from acceptance until the response is taken.

Top module: `bus_window_xlat`

## Requirements
- R1: A request is accepted only when `req_addr[31:30]` is `2'b10` and no transaction is in flight. Any other address leaves `req_ready` low and starts no bus cycle.
- R2: In memory mode, `bus_addr` is the top-bits field (misc register bits 3:2) followed by `req_addr[29:0]`. The command is 0x6 for a read and 0x7 for a write.
- R3: Misc register bit 1 set to 1 selects configuration mode, which uses command 0xA for a read and 0xB for a write. The window offset is decoded as device = bits 15:11, function = bits 10:8 and register = bits 7:0. The bus address is (1 << (13+device)) | (function << 8) | (register with bits 1:0 cleared).
- R4: A configuration request is rejected when offset bits 29:16 are nonzero, when the device number exceeds 18, or when the IDSEL bit would sit at bit 20 or above. A rejected request produces no bus cycle, and its response has status 2'b01.
- R5: A completion with `bus_abort` high sets bit 26 of the status register (`ctl_sel`=1). Writing 1 to bit 26 of that register clears it. If a set and a clear happen in the same cycle, the set wins.
- R6: A successful read returns `bus_rdata` with status 2'b00. A read that is rejected or aborted returns 0xFFFFFFFF, and an aborted cycle has status 2'b10. Every write response returns 0.
- R7: `bus_wdata` and `bus_be` equal the write data and byte enables of the accepted request, unchanged.
- R8: While `bus_ready` is low, the bus command stays valid and unchanged. While `rsp_ready` is low, the response stays valid and unchanged.
- R9: The misc register (`ctl_sel`=0) reads back the full 32-bit word last written to it. Request traffic never changes it, and the cycle type is taken at acceptance.
- R10: After reset, no valid output is high, and both control registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request valid |
| req_ready | output | 1 | Local request accepted |
| req_addr | input | 32 | Local request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Local write data |
| req_be | input | 4 | Local byte enables |
| bus_valid | output | 1 | Bus command valid |
| bus_ready | input | 1 | Bus command taken |
| bus_cmd | output | 4 | Bus command code |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_be | output | 4 | Bus byte enables |
| bus_done | input | 1 | Bus cycle completion pulse |
| bus_abort | input | 1 | Completion ended in abort |
| bus_rdata | input | 32 | Bus read data at completion |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Response read data |
| rsp_status | output | 2 | 00 ok, 01 rejected, 10 aborted |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_sel | input | 1 | 0 = misc register, 1 = status register |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Selected control register contents |

## Verification
Each output has a fixed delay from its cause:

| Output | When it is due |
|---|---|
| `req_ready` | In the same cycle as the address, since it is combinational |
| `bus_valid` | The cycle after acceptance |
| Response for a normal request | The cycle after the edge that samples `bus_done` |
| Response for a rejected request | The cycle after acceptance |
| Abort flag and misc register contents | The cycle after the edge that writes them |

The bench model advances its phase and register copies on each rising edge, using the same input values the design samples. Every output is compared with the model at the following falling edge, so each check lands in the cycle where its result is due. Stalls on both ready inputs test hold behaviour over several cycles.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [3:0] {
    CMD_MEM_RD = 4'h6,
    CMD_MEM_WR = 4'h7,
    CMD_CFG_RD = 4'hA,
    CMD_CFG_WR = 4'hB
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_OK  = 2'b00,
    ST_REJ = 2'b01,
    ST_ABT = 2'b10
  } rsp_stat_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_WAIT,
    PH_RESP
  } phase_e;
endpackage

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs #(
  parameter int DATA_W    = 32,
  parameter int MODE_BIT  = 1,
  parameter int HI_LSB    = 2,
  parameter int ABORT_BIT = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_sel,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              abort_evt,
  output logic              cfg_mode,
  output logic [1:0]        hi_bits,
  output logic [DATA_W-1:0] ctl_rdata
);
  logic [DATA_W-1:0] misc_q;
  logic              abort_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      if (ctl_wr && !ctl_sel) misc_q <= ctl_wdata;
      if (abort_evt) abort_q <= 1'b1;
      else if (ctl_wr && ctl_sel && ctl_wdata[ABORT_BIT]) abort_q <= 1'b0;
    end
  end

  assign cfg_mode = misc_q[MODE_BIT];
  assign hi_bits  = misc_q[HI_LSB +: 2];

  always_comb begin
    ctl_rdata = '0;
    if (ctl_sel) ctl_rdata[ABORT_BIT] = abort_q;
    else         ctl_rdata = misc_q;
  end

  assert_abort_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> abort_q);
  assert_misc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(misc_q));
endmodule

// File: rtl/xlat_decode.sv
module xlat_decode
  import xlat_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter logic [1:0]  WIN_TAG     = 2'b10,
  parameter int          FUNC_LSB    = 8,
  parameter int          FUNC_W      = 3,
  parameter int          DEV_W       = 5,
  parameter int          IDSEL_BASE  = 13,
  parameter int          MAX_DEV     = 18,
  parameter int          CFG_SPAN_LG = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              cfg_mode,
  input  logic [1:0]        hi_bits,
  output logic              hit,
  output logic              reject,
  output bus_cmd_e          cmd,
  output logic [ADDR_W-1:0] xaddr
);
  localparam int OFF_W   = ADDR_W - 2;
  localparam int DEV_LSB = FUNC_LSB + FUNC_W;
  localparam int TOP_LSB = DEV_LSB + DEV_W;
  localparam int POS_W   = $clog2(ADDR_W) + 2;

  logic [OFF_W-1:0]  offset;
  logic [DEV_W-1:0]  dev;
  logic [POS_W-1:0]  idsel_pos;
  logic              upper_nz, dev_big, too_far;
  logic [ADDR_W-1:0] cfg_addr, mem_addr;

  assign hit       = (addr[ADDR_W-1 -: 2] == WIN_TAG);
  assign offset    = addr[OFF_W-1:0];
  assign dev       = offset[DEV_LSB +: DEV_W];
  assign idsel_pos = POS_W'(IDSEL_BASE) + POS_W'(dev);
  assign upper_nz  = |offset[OFF_W-1:TOP_LSB];
  assign dev_big   = dev > DEV_W'(MAX_DEV);
  assign too_far   = idsel_pos >= POS_W'(CFG_SPAN_LG);
  assign reject    = cfg_mode && (upper_nz || dev_big || too_far);
  assign mem_addr  = {hi_bits, offset};

  always_comb begin
    cfg_addr = {{(ADDR_W-1){1'b0}}, 1'b1} << idsel_pos;
    cfg_addr[FUNC_LSB +: FUNC_W] = offset[FUNC_LSB +: FUNC_W];
    cfg_addr[FUNC_LSB-1:0] = offset[FUNC_LSB-1:0] & ~(FUNC_LSB'(3));
  end

  always_comb begin
    if (cfg_mode) begin
      cmd   = write ? CMD_CFG_WR : CMD_CFG_RD;
      xaddr = cfg_addr;
    end else begin
      cmd   = write ? CMD_MEM_WR : CMD_MEM_RD;
      xaddr = mem_addr;
    end
  end
endmodule

// File: rtl/xlat_seq.sv
module xlat_seq
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              hit,
  input  logic              reject,
  input  bus_cmd_e          cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              req_ready,
  output logic              bus_valid,
  input  logic              bus_ready,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [BE_W-1:0]   bus_be,
  input  logic              bus_done,
  input  logic              bus_abort,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output rsp_stat_e         rsp_status,
  output logic              abort_evt
);
  phase_e ph_q;
  logic   wr_q;
  logic   accept;

  assign req_ready = (ph_q == PH_IDLE) && hit;
  assign accept    = req_valid && req_ready;
  assign bus_valid = (ph_q == PH_ISSUE);
  assign rsp_valid = (ph_q == PH_RESP);
  assign abort_evt = (ph_q == PH_WAIT) && bus_done && bus_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      wr_q       <= 1'b0;
      bus_cmd    <= CMD_MEM_RD;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      bus_be     <= '0;
      rsp_rdata  <= '0;
      rsp_status <= ST_OK;
    end else begin
      case (ph_q)
        PH_IDLE: if (accept) begin
          wr_q      <= req_write;
          bus_cmd   <= cmd_in;
          bus_addr  <= addr_in;
          bus_wdata <= req_wdata;
          bus_be    <= req_be;
          if (reject) begin
            ph_q       <= PH_RESP;
            rsp_status <= ST_REJ;
            rsp_rdata  <= req_write ? '0 : '1;
          end else begin
            ph_q <= PH_ISSUE;
          end
        end
        PH_ISSUE: if (bus_ready) ph_q <= PH_WAIT;
        PH_WAIT: if (bus_done) begin
          ph_q       <= PH_RESP;
          rsp_status <= bus_abort ? ST_ABT : ST_OK;
          rsp_rdata  <= wr_q ? '0 : (bus_abort ? '1 : bus_rdata);
        end
        default: if (rsp_ready) ph_q <= PH_IDLE;
      endcase
    end
  end

  assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_cmd)
      && $stable(bus_wdata) && $stable(bus_be));
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_status));
  assert_reject_no_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && reject |=> !bus_valid && rsp_valid && rsp_status == ST_REJ);
  assert_abort_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !wr_q && rsp_status != ST_OK |-> rsp_rdata == '1);
  assert_single_flight_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid || rsp_valid) |-> !req_ready);
endmodule

// File: rtl/bus_window_xlat.sv
module bus_window_xlat
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [3:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [BE_W-1:0]   bus_be,
  input  logic              bus_done,
  input  logic              bus_abort,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_status,
  input  logic              ctl_wr,
  input  logic              ctl_sel,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata
);
  localparam logic [1:0] WIN_TAG    = 2'b10;
  localparam int         IDSEL_BASE = 13;

  logic              cfg_mode, hit, reject, abort_evt;
  logic [1:0]        hi_bits;
  bus_cmd_e          dec_cmd, q_cmd;
  logic [ADDR_W-1:0] dec_addr;
  rsp_stat_e         q_stat;

  xlat_ctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel),
    .ctl_wdata(ctl_wdata), .abort_evt(abort_evt), .cfg_mode(cfg_mode),
    .hi_bits(hi_bits), .ctl_rdata(ctl_rdata)
  );

  xlat_decode #(.ADDR_W(ADDR_W), .WIN_TAG(WIN_TAG), .IDSEL_BASE(IDSEL_BASE)) u_dec (
    .addr(req_addr), .write(req_write), .cfg_mode(cfg_mode), .hi_bits(hi_bits),
    .hit(hit), .reject(reject), .cmd(dec_cmd), .xaddr(dec_addr)
  );

  xlat_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(hit), .reject(reject),
    .cmd_in(dec_cmd), .addr_in(dec_addr), .req_write(req_write),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_cmd(q_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_done(bus_done), .bus_abort(bus_abort), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_status(q_stat), .abort_evt(abort_evt)
  );

  assign bus_cmd    = q_cmd;
  assign rsp_status = q_stat;

  assert_outside_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr[ADDR_W-1 -: 2] != WIN_TAG |-> !req_ready);
  assert_cfg_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && (bus_cmd == CMD_CFG_RD || bus_cmd == CMD_CFG_WR)
      |-> $countones(bus_addr[ADDR_W-1:IDSEL_BASE]) == 1);
  assert_be_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bus_be == $past(req_be) && bus_wdata == $past(req_wdata));
endmodule

// File: tb/test_bus_window_xlat.sv
`timescale 1ns/1ps
module test_bus_window_xlat;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, bus_ready = 1, bus_done = 0, bus_abort = 0;
  logic        rsp_ready = 1, ctl_wr = 0, ctl_sel = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, bus_rdata = 0, ctl_wdata = 0;
  logic [3:0]  req_be = 0;
  logic        req_ready, bus_valid, rsp_valid;
  logic [3:0]  bus_cmd, bus_be;
  logic [31:0] bus_addr, bus_wdata, rsp_rdata, ctl_rdata;
  logic [1:0]  rsp_status;

  int total = 0, bad = 0;
  bit running = 0;

  always #2.5 clk = ~clk;

  bus_window_xlat i_bus_window_xlat (.*);

  // behavioural reference: phases 0 idle, 1 issue, 2 wait, 3 response
  int          m_st = 0;
  bit          m_acc = 0, m_hs = 0, m_abort = 0, m_wr = 0;
  logic [31:0] m_misc = 0, m_addr = 0, m_wd = 0, m_rdata = 0;
  logic [3:0]  m_cmd = 0, m_be = 0;
  logic [1:0]  m_stat = 0;
  bit          r_abort = 0;
  logic [31:0] r_rdata = 0;

  function automatic bit in_win(logic [31:0] a);
    return a[31:30] == 2'b10;
  endfunction

  always @(posedge clk) begin
    logic [31:0] off;
    int dev;
    bit cfg, evt;
    m_acc = 0; m_hs = 0; evt = 0;
    if (!rst_n) begin
      m_st = 0; m_misc = 0; m_abort = 0;
    end else begin
      cfg = m_misc[1];
      case (m_st)
        0: if (req_valid && in_win(req_addr)) begin
          m_acc = 1; m_wr = req_write; m_wd = req_wdata; m_be = req_be;
          off = {2'b00, req_addr[29:0]};
          dev = int'((off >> 11) & 32'h1F);
          if (cfg) begin
            m_cmd  = req_write ? 4'hB : 4'hA;
            m_addr = (32'd1 << (13 + dev)) | (((off >> 8) & 32'h7) << 8) | (off & 32'hFC);
          end else begin
            m_cmd  = req_write ? 4'h7 : 4'h6;
            m_addr = {m_misc[3:2], req_addr[29:0]};
          end
          if (cfg && ((off >> 16) != 0 || dev > 18 || 13 + dev >= 20)) begin
            m_st = 3; m_stat = 2'b01; m_rdata = req_write ? 32'h0 : 32'hFFFF_FFFF;
          end else m_st = 1;
        end
        1: if (bus_ready) begin m_st = 2; m_hs = 1; end
        2: if (bus_done) begin
          m_st = 3;
          m_stat = bus_abort ? 2'b10 : 2'b00;
          m_rdata = m_wr ? 32'h0 : (bus_abort ? 32'hFFFF_FFFF : bus_rdata);
          evt = bus_abort;
        end
        default: if (rsp_ready) m_st = 0;
      endcase
      if (ctl_wr && !ctl_sel) m_misc = ctl_wdata;
      if (evt) m_abort = 1;
      else if (ctl_wr && ctl_sel && ctl_wdata[26]) m_abort = 0;
    end
  end

  // bus responder: completes one cycle after each command handshake
  always @(posedge clk) begin
    #1;
    bus_done  = m_hs;
    bus_abort = m_hs ? r_abort : 1'b0;
    bus_rdata = r_rdata;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk("R1 req_ready", 32'(req_ready), 32'(m_st == 0 && in_win(req_addr)));
    chk("R8 bus_valid", 32'(bus_valid), 32'(m_st == 1));
    chk("R8 rsp_valid", 32'(rsp_valid), 32'(m_st == 3));
    chk(ctl_sel ? "R5 status reg" : "R9 misc reg", ctl_rdata,
        ctl_sel ? (32'(m_abort) << 26) : m_misc);
    if (m_st == 1) begin
      chk(m_cmd[3] ? "R3 cfg cmd" : "R2 mem cmd", 32'(bus_cmd), 32'(m_cmd));
      chk(m_cmd[3] ? "R3 cfg addr" : "R2 mem addr", bus_addr, m_addr);
      chk("R7 wdata", bus_wdata, m_wd);
      chk("R7 be", 32'(bus_be), 32'(m_be));
    end
    if (m_st == 3) begin
      chk(m_stat == 2'b01 ? "R4 status" : "R6 status", 32'(rsp_status), 32'(m_stat));
      chk("R6 rdata", rsp_rdata, m_rdata);
    end
  end

  task automatic send(logic [31:0] a, bit we, logic [31:0] wd, logic [3:0] be,
                      bit ab, logic [31:0] rd, int bstall, int rstall);
    @(posedge clk); #1;
    req_addr = a; req_write = we; req_wdata = wd; req_be = be; req_valid = 1;
    r_abort = ab; r_rdata = rd;
    bus_ready = (bstall == 0); rsp_ready = (rstall == 0);
    do begin @(posedge clk); #1; end while (!m_acc);
    req_valid = 0;
    repeat (bstall) begin @(posedge clk); #1; end
    bus_ready = 1;
    while (m_st != 3 && m_st != 0) begin @(posedge clk); #1; end
    repeat (rstall) begin @(posedge clk); #1; end
    rsp_ready = 1;
    while (m_st != 0) begin @(posedge clk); #1; end
  endtask

  task automatic outside(logic [31:0] a);
    @(posedge clk); #1;
    req_addr = a; req_write = 0; req_valid = 1;
    repeat (4) begin @(posedge clk); #1; end
    req_valid = 0;
  endtask

  task automatic ctl(bit sel, logic [31:0] wd);
    @(posedge clk); #1;
    ctl_wr = 1; ctl_sel = sel; ctl_wdata = wd;
    @(posedge clk); #1;
    ctl_wr = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10 bus_valid", 32'(bus_valid), 0);
    chk("R10 rsp_valid", 32'(rsp_valid), 0);
    chk("R10 misc", ctl_rdata, 0);
    running = 1;
    // R2: memory read, top bits zero
    send(32'h8000_1234, 0, 0, 4'hF, 0, 32'h1234_ABCD, 0, 0);
    // R2 R7: memory write with top bits 2'b11 and partial byte enables
    ctl(0, 32'h0000_000C);
    send(32'hBFFF_FFFC, 1, 32'hCAFE_F00D, 4'b0101, 0, 0, 0, 0);
    // R1: outside the window is never claimed
    outside(32'h4000_0000);
    outside(32'hC000_0010);
    // R3: configuration reads and writes
    ctl(0, 32'h0000_0002);
    send(32'h8000_1913, 0, 0, 4'hF, 0, 32'h00FF_1168, 0, 0);
    send(32'h8000_37FC, 1, 32'h0000_0146, 4'b0011, 0, 0, 0, 0);
    send(32'h8000_0004, 0, 0, 4'hF, 0, 32'h5A5A_5A5A, 0, 0);
    // R4: rejected configuration requests
    send(32'h8000_3800, 0, 0, 4'hF, 0, 32'h1111_1111, 0, 0);
    send(32'h8000_9800, 0, 0, 4'hF, 0, 32'h1111_1111, 0, 0);
    send(32'h8001_0000, 0, 0, 4'hF, 0, 32'h1111_1111, 0, 0);
    send(32'h8000_3800, 1, 32'h1, 4'hF, 0, 0, 2, 2);
    // R6 R5: aborted reads in memory mode, flag readback and clear
    ctl(0, 32'h0000_0008);
    ctl_sel = 1;
    send(32'h8000_0040, 0, 0, 4'hF, 1, 32'h2222_2222, 0, 0);
    ctl(1, 32'h0400_0000);
    ctl_sel = 1;
    // R5: clear held during an abort, set wins on the colliding edge
    @(posedge clk); #1;
    ctl_wr = 1; ctl_sel = 1; ctl_wdata = 32'h0400_0000;
    send(32'h8000_0044, 1, 32'h3, 4'hF, 1, 0, 0, 0);
    @(posedge clk); #1;
    ctl_wr = 0; ctl_sel = 0;
    // R8: back-pressure on both sides
    send(32'h8123_4560, 0, 0, 4'b1000, 0, 32'h7777_0001, 3, 4);
    send(32'h8123_4564, 1, 32'hDEAD_BEEF, 4'b0110, 0, 0, 2, 1);
    // R9: config-mode select taken at acceptance, misc unchanged by traffic
    ctl(0, 32'hA5A5_0002);
    send(32'h8000_0810, 1, 32'h9, 4'hF, 0, 0, 0, 0);
    ctl(0, 32'h0000_0000);
    send(32'h8000_0810, 0, 0, 4'hF, 0, 32'h4242_4242, 0, 0);
    repeat (3) @(posedge clk);
    running = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule